// File: doc/BRIEF.md
# Serial Port Companding Datapath

This block is the word-conversion stage of a serial port. It sits between the 16-bit parallel data registers and the 8-bit serial shift path. On the transmit side, a load strobe copies a 16-bit twos-complement sample into the shift-out word. A 2-bit mode selects how the sample is converted on the way:

- a raw pass-through;
- a raw byte reversed so that it leaves least significant bit first;
- an 8-bit mu-law code;
- an 8-bit A-law code.

The stage also reports how many bits the shifter must send for that word.

On the receive side, a second load strobe copies the receive buffer into the parallel data word. The buffer holds an 8-bit code or raw bits, and the receive mode selects how it is expanded back into 16-bit twos-complement form.

Each copy takes one clock. A one-cycle valid pulse marks a new word, and the mode is captured together with the data. Outputs hold their value until the next strobe.

Top module: `sport_compand`

## Requirements
- R1: While reset is asserted and until the first strobe after it, tx_shift_word, tx_bits, tx_valid, rx_word and rx_valid are all zero.
- R2: Transmit mode 00 copies tx_data unchanged into tx_shift_word. It sets tx_bits from tx_wdlen as follows: 000 gives 8, 001 gives 12, 010 gives 16, and any larger code is capped at the 16-bit data width.
- R3: Transmit mode 01 places tx_data[7:0] in bit-reversed order in tx_shift_word[7:0] and clears the upper byte. An MSB-first shifter therefore emits the original least significant bit first.
- R4: Transmit mode 10 produces a mu-law code in tx_shift_word[7:0] with the upper byte cleared:
  - The sample's absolute value is capped at 8158, then a bias of 33 is added.
  - The segment s is the highest set bit position of the biased value minus 5, or 0 if no bit at position 5 or above is set.
  - The mantissa is bits s+4..s+1 of the biased value.
  - The code is the bitwise complement of {negative, s, mantissa}.
- R5: Transmit mode 11 produces an A-law code in tx_shift_word[7:0] with the upper byte cleared:
  - The magnitude is the sample for a non-negative input and -sample-1 for a negative one, capped at 4095.
  - The segment s is the highest set bit position minus 4 for a magnitude of 32 or more, and 0 otherwise.
  - The mantissa is bits 4..1 of the magnitude when s is 0, and bits s+3..s otherwise.
  - The code is {non-negative, s, mantissa} XOR 0x55.
- R6: In transmit modes 01, 10 and 11, tx_bits is 8 whatever tx_wdlen holds.
- R7: Receive mode 00 copies rx_buf unchanged. Mode 01 bit-reverses rx_buf[7:0] and zero-fills the rest. Mode 10 expands a mu-law code and mode 11 expands an A-law code, each into a sign-extended 16-bit sample.
  - Mu-law: complement the code, then the magnitude is (2*mantissa+33)*2^segment-33, negative when the top bit of the complemented code is set.
  - A-law: XOR the code with 0x55. The magnitude is 2*mantissa+1 for segment 0 and (2*mantissa+33)*2^(segment-1) otherwise, positive when the top bit is set.
- R8: A strobe at one clock edge updates the matching output word and raises its valid flag at that edge. The valid flag is high for exactly one cycle per strobe.
- R9: Without a strobe, changes to mode, data or word length have no effect: output words and tx_bits hold their last value and valid stays low.
- R10: Out-of-range inputs saturate before encoding. With mu-law, any sample of 8158 or more codes to 0x80 and any sample of -8158 or less codes to 0x00. With A-law, any sample of 4095 or more codes to 0xAA and any sample of -4096 or less codes to 0x2A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_load | input | 1 | Copy strobe for the transmit word |
| tx_mode | input | 2 | Transmit conversion mode |
| tx_wdlen | input | 3 | Configured serial word length code |
| tx_data | input | 16 | Transmit sample, twos complement |
| tx_shift_word | output | 16 | Word presented to the shift-out stage |
| tx_bits | output | 5 | Number of bits the shifter sends |
| tx_valid | output | 1 | One-cycle pulse marking a new transmit word |
| rx_load | input | 1 | Copy strobe for the receive word |
| rx_mode | input | 2 | Receive conversion mode |
| rx_buf | input | 16 | Receive buffer contents |
| rx_word | output | 16 | Expanded receive data word |
| rx_valid | output | 1 | One-cycle pulse marking a new receive word |

## Verification
Directed samples test each encoding law at its critical points: zero, where the two laws differ in how the sign is treated, and both full-scale limits plus values well beyond them, where saturation must land on the extreme codes. Random samples drawn from three pools cover segment and mantissa selection across every segment in every mode and word-length code. The pools are full 16-bit words, values within the law ranges, and values near the saturation knees. Receive codes are drawn uniformly over all 256 values, so every segment of both expansion laws is decoded. Mode and data changes between strobes, as well as checks on the cycle after each strobe, separate the copy timing from the conversion.

// File: rtl/sport_compand_pkg.sv
package sport_compand_pkg;

   typedef enum logic [1:0] {
      MODE_RAW     = 2'b00,
      MODE_RAW_LSB = 2'b01,
      MODE_MULAW   = 2'b10,
      MODE_ALAW    = 2'b11
   } cmode_e;

   localparam int CODE_W  = 8;
   localparam int WDLEN_W = 3;

endpackage

// File: rtl/g711_compress.sv
module g711_compress #(
   parameter int LAW_A    = 0,
   parameter int DATA_W   = 16,
   parameter int SIG_BITS = 14
) (
   input  logic [DATA_W-1:0] sample,
   output logic [7:0]        code
);
   localparam int MAG_W = SIG_BITS - 1;
   localparam int HI    = 2**(SIG_BITS-1) - 1;

   if (DATA_W < SIG_BITS) begin : g_bad_width
      $error("g711_compress: DATA_W smaller than SIG_BITS");
   end

   if (LAW_A == 0) begin : g_mu
      localparam int BIAS = 33;
      localparam int CLIP = HI - BIAS;
      if (SIG_BITS != 14) begin : g_bad_mu
         $error("g711_compress: mu-law needs 14 significant bits");
      end
      logic              neg;
      logic [DATA_W-1:0] mag;
      logic [MAG_W-1:0]  mag_c;
      logic [MAG_W-1:0]  biased;
      logic [MAG_W-1:0]  shifted;
      logic [2:0]        seg;
      always_comb begin
         neg     = sample[DATA_W-1];
         mag     = neg ? (~sample + 1'b1) : sample;
         mag_c   = (mag > CLIP) ? MAG_W'(CLIP) : mag[MAG_W-1:0];
         biased  = mag_c + MAG_W'(BIAS);
         seg     = 3'd0;
         for (int i = 5; i < MAG_W; i++) begin
            if (biased[i]) seg = 3'(i - 5);
         end
         shifted = biased >> ({1'b0, seg} + 4'd1);
         code    = ~{neg, seg, shifted[3:0]};
      end
   end else begin : g_alaw
      if (SIG_BITS != 13) begin : g_bad_a
         $error("g711_compress: A-law needs 13 significant bits");
      end
      logic              nonneg;
      logic [DATA_W-1:0] mag_full;
      logic [MAG_W-1:0]  mag;
      logic [MAG_W-1:0]  shifted;
      logic [2:0]        seg;
      always_comb begin
         nonneg   = ~sample[DATA_W-1];
         mag_full = nonneg ? sample : ~sample;
         mag      = (mag_full > HI) ? MAG_W'(HI) : mag_full[MAG_W-1:0];
         seg      = 3'd0;
         for (int i = 5; i < MAG_W; i++) begin
            if (mag[i]) seg = 3'(i - 4);
         end
         shifted  = (seg == 3'd0) ? (mag >> 1) : (mag >> seg);
         code     = {nonneg, seg, shifted[3:0]} ^ 8'h55;
      end
   end

endmodule

// File: rtl/g711_expand.sv
module g711_expand #(
   parameter int LAW_A    = 0,
   parameter int DATA_W   = 16,
   parameter int SIG_BITS = 14
) (
   input  logic [7:0]        code,
   output logic [DATA_W-1:0] sample
);
   localparam int MAG_W = SIG_BITS - 1;

   if (DATA_W < SIG_BITS) begin : g_bad_width
      $error("g711_expand: DATA_W smaller than SIG_BITS");
   end

   if (LAW_A == 0) begin : g_mu
      logic [7:0]       c;
      logic [MAG_W-1:0] t;
      logic [MAG_W-1:0] mag;
      always_comb begin
         c      = ~code;
         t      = (MAG_W'({c[3:0], 1'b1}) + MAG_W'(32)) << c[6:4];
         mag    = t - MAG_W'(33);
         sample = c[7] ? (~DATA_W'(mag) + 1'b1) : DATA_W'(mag);
      end
   end else begin : g_alaw
      logic [7:0]       c;
      logic [MAG_W-1:0] base;
      logic [MAG_W-1:0] mag;
      always_comb begin
         c    = code ^ 8'h55;
         base = MAG_W'({c[3:0], 1'b1});
         if (c[6:4] == 3'd0) mag = base;
         else                mag = (base + MAG_W'(32)) << (c[6:4] - 3'd1);
         sample = c[7] ? DATA_W'(mag) : (~DATA_W'(mag) + 1'b1);
      end
   end

endmodule

// File: rtl/sport_compand.sv
module sport_compand
   import sport_compand_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int MU_BITS = 14,
   parameter int A_BITS  = 13,
   parameter int BITS_W  = $clog2(DATA_W) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_load,
   input  logic [1:0]          tx_mode,
   input  logic [2:0]          tx_wdlen,
   input  logic [DATA_W-1:0]   tx_data,
   output logic [DATA_W-1:0]   tx_shift_word,
   output logic [BITS_W-1:0]   tx_bits,
   output logic                tx_valid,
   input  logic                rx_load,
   input  logic [1:0]          rx_mode,
   input  logic [DATA_W-1:0]   rx_buf,
   output logic [DATA_W-1:0]   rx_word,
   output logic                rx_valid
);
   localparam int UPPER_W = DATA_W - CODE_W;
   localparam int MU_SAT  = 2**(MU_BITS-1) - 1 - 33;
   localparam int A_SAT   = 2**(A_BITS-1) - 1;
   localparam int MU_PEAK = (63 << 7) - 33;
   localparam int A_PEAK  = 63 << 6;

   if (DATA_W < MU_BITS || DATA_W <= CODE_W) begin : g_bad_top
      $error("sport_compand: DATA_W too small for the companding laws");
   end

   function automatic logic [BITS_W-1:0] len_of(input logic [WDLEN_W-1:0] wl);
      int n;
      case (wl)
         3'd0:    n = 8;
         3'd1:    n = 12;
         3'd2:    n = 16;
         3'd3:    n = 20;
         3'd4:    n = 24;
         default: n = 32;
      endcase
      if (n > DATA_W) n = DATA_W;
      return BITS_W'(n);
   endfunction

   // transmit conversion
   logic [CODE_W-1:0] tx_rev, tx_mu, tx_a;
   logic [DATA_W-1:0] tx_next;
   logic [BITS_W-1:0] tx_bits_next;

   for (genvar i = 0; i < CODE_W; i++) begin : g_tx_rev
      assign tx_rev[i] = tx_data[CODE_W-1-i];
   end

   g711_compress #(.LAW_A(0), .DATA_W(DATA_W), .SIG_BITS(MU_BITS)) u_tx_mu (
      .sample(tx_data), .code(tx_mu));
   g711_compress #(.LAW_A(1), .DATA_W(DATA_W), .SIG_BITS(A_BITS)) u_tx_a (
      .sample(tx_data), .code(tx_a));

   always_comb begin
      case (cmode_e'(tx_mode))
         MODE_RAW:     tx_next = tx_data;
         MODE_RAW_LSB: tx_next = {{UPPER_W{1'b0}}, tx_rev};
         MODE_MULAW:   tx_next = {{UPPER_W{1'b0}}, tx_mu};
         default:      tx_next = {{UPPER_W{1'b0}}, tx_a};
      endcase
      tx_bits_next = (tx_mode == MODE_RAW) ? len_of(tx_wdlen) : BITS_W'(CODE_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_shift_word <= '0;
         tx_bits       <= '0;
         tx_valid      <= 1'b0;
      end else begin
         tx_valid <= tx_load;
         if (tx_load) begin
            tx_shift_word <= tx_next;
            tx_bits       <= tx_bits_next;
         end
      end
   end

   // receive conversion
   logic [CODE_W-1:0] rx_rev;
   logic [DATA_W-1:0] rx_mu, rx_a, rx_next;

   for (genvar i = 0; i < CODE_W; i++) begin : g_rx_rev
      assign rx_rev[i] = rx_buf[CODE_W-1-i];
   end

   g711_expand #(.LAW_A(0), .DATA_W(DATA_W), .SIG_BITS(MU_BITS)) u_rx_mu (
      .code(rx_buf[CODE_W-1:0]), .sample(rx_mu));
   g711_expand #(.LAW_A(1), .DATA_W(DATA_W), .SIG_BITS(A_BITS)) u_rx_a (
      .code(rx_buf[CODE_W-1:0]), .sample(rx_a));

   always_comb begin
      case (cmode_e'(rx_mode))
         MODE_RAW:     rx_next = rx_buf;
         MODE_RAW_LSB: rx_next = {{UPPER_W{1'b0}}, rx_rev};
         MODE_MULAW:   rx_next = rx_mu;
         default:      rx_next = rx_a;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= rx_load;
         if (rx_load) rx_word <= rx_next;
      end
   end

   // checks
   a_r8_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> tx_valid);
   a_r8_tx_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_load |=> !tx_valid);
   a_r8_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> rx_valid);
   a_r6_forced_len: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && tx_mode != MODE_RAW) |=> tx_bits == BITS_W'(CODE_W));
   a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && tx_mode != MODE_RAW) |=> tx_shift_word[DATA_W-1:CODE_W] == '0);
   a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_load |=> ($stable(tx_shift_word) && $stable(tx_bits)));
   a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_load |=> $stable(rx_word));
   a_r10_mu_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && tx_mode == MODE_MULAW && $signed(tx_data) >= MU_SAT)
      |=> tx_shift_word[CODE_W-1:0] == 8'h80);
   a_r10_a_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && tx_mode == MODE_ALAW && $signed(tx_data) >= A_SAT)
      |=> tx_shift_word[CODE_W-1:0] == 8'hAA);
   a_r7_mu_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load && rx_mode == MODE_MULAW)
      |=> ($signed(rx_word) <= MU_PEAK && $signed(rx_word) >= -MU_PEAK));
   a_r7_a_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load && rx_mode == MODE_ALAW)
      |=> ($signed(rx_word) <= A_PEAK && $signed(rx_word) >= -A_PEAK));

endmodule

// File: tb/sport_compand_test.sv
module sport_compand_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_load = 1'b0, rx_load = 1'b0;
   logic [1:0]  tx_mode = 2'b00, rx_mode = 2'b00;
   logic [2:0]  tx_wdlen = 3'b000;
   logic [15:0] tx_data = '0, rx_buf = '0;
   logic [15:0] tx_shift_word, rx_word;
   logic [4:0]  tx_bits;
   logic        tx_valid, rx_valid;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   sport_compand uut (
      .clk(clk), .rst_n(rst_n),
      .tx_load(tx_load), .tx_mode(tx_mode), .tx_wdlen(tx_wdlen), .tx_data(tx_data),
      .tx_shift_word(tx_shift_word), .tx_bits(tx_bits), .tx_valid(tx_valid),
      .rx_load(rx_load), .rx_mode(rx_mode), .rx_buf(rx_buf),
      .rx_word(rx_word), .rx_valid(rx_valid));

   always #5 clk = ~clk;

   function automatic logic [7:0] m_enc(input logic [15:0] d);
      int x = int'($signed(d));
      int s = (x < 0) ? 1 : 0;
      int m = (x < 0) ? -x : x;
      int b, seg, mant;
      if (m > 8158) m = 8158;
      b = m + 33;
      seg = 0;
      for (int k = 1; k < 8; k++) if (b >= (32 << k)) seg = k;
      mant = (b >> (seg + 1)) % 16;
      return 8'(((s << 7) | (seg << 4) | mant) ^ 255);
   endfunction

   function automatic logic [7:0] a_enc(input logic [15:0] d);
      int x = int'($signed(d));
      int s = (x >= 0) ? 1 : 0;
      int m = (x >= 0) ? x : -x - 1;
      int seg, mant;
      if (m > 4095) m = 4095;
      seg = 0;
      for (int k = 1; k < 8; k++) if (m >= (16 << k)) seg = k;
      mant = (seg == 0) ? (m >> 1) % 16 : (m >> seg) % 16;
      return 8'(((s << 7) | (seg << 4) | mant) ^ 'h55);
   endfunction

   function automatic logic [15:0] m_dec(input logic [7:0] c);
      int v = int'(c) ^ 255;
      int seg = (v >> 4) & 7;
      int mag = ((v & 15) * 2 + 33) * (1 << seg) - 33;
      return 16'((v >= 128) ? -mag : mag);
   endfunction

   function automatic logic [15:0] a_dec(input logic [7:0] c);
      int v = int'(c) ^ 'h55;
      int seg = (v >> 4) & 7;
      int mant = v & 15;
      int mag = (seg == 0) ? mant * 2 + 1 : (mant * 2 + 33) * (1 << (seg - 1));
      return 16'((v >= 128) ? mag : -mag);
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = b[7-k];
      return r;
   endfunction

   function automatic logic [15:0] exp_tx(input logic [1:0] md, input logic [15:0] d);
      case (md)
         2'b00:   return d;
         2'b01:   return {8'h00, rev8(d[7:0])};
         2'b10:   return {8'h00, m_enc(d)};
         default: return {8'h00, a_enc(d)};
      endcase
   endfunction

   function automatic logic [4:0] exp_bits(input logic [1:0] md, input logic [2:0] wl);
      if (md != 2'b00) return 5'd8;
      if (wl == 3'd0) return 5'd8;
      if (wl == 3'd1) return 5'd12;
      return 5'd16;
   endfunction

   function automatic logic [15:0] exp_rx(input logic [1:0] md, input logic [15:0] d);
      case (md)
         2'b00:   return d;
         2'b01:   return {8'h00, rev8(d[7:0])};
         2'b10:   return m_dec(d[7:0]);
         default: return a_dec(d[7:0]);
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tx_word(input logic [1:0] md, input logic [2:0] wl,
                          input logic [15:0] d, input string req);
      @(negedge clk);
      tx_mode = md; tx_wdlen = wl; tx_data = d; tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
      chk(req, "tx_valid", 32'(tx_valid), 32'd1);
      chk(req, "tx_shift_word", 32'(tx_shift_word), 32'(exp_tx(md, d)));
      chk(req, "tx_bits", 32'(tx_bits), 32'(exp_bits(md, wl)));
   endtask

   task automatic rx_word_t(input logic [1:0] md, input logic [15:0] d, input string req);
      @(negedge clk);
      rx_mode = md; rx_buf = d; rx_load = 1'b1;
      @(negedge clk);
      rx_load = 1'b0;
      chk(req, "rx_valid", 32'(rx_valid), 32'd1);
      chk(req, "rx_word", 32'(rx_word), 32'(exp_rx(md, d)));
   endtask

   function automatic logic [15:0] pick_sample();
      int sel = int'($urandom % 3);
      if (sel == 0) return 16'($urandom);
      if (sel == 1) return 16'(int'($urandom % 16384) - 8192);
      return 16'(int'($urandom % 400) + ((($urandom % 2) == 0) ? 3900 : 7950)
                 * ((($urandom % 2) == 0) ? 1 : -1));
   endfunction

   initial begin
      logic [15:0] held;
      logic [4:0]  held_bits;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", "tx_valid in reset", 32'(tx_valid), 32'd0);
      chk("R1", "tx_shift_word in reset", 32'(tx_shift_word), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "tx_bits after reset", 32'(tx_bits), 32'd0);
      chk("R1", "rx_word after reset", 32'(rx_word), 32'd0);
      chk("R1", "rx_valid after reset", 32'(rx_valid), 32'd0);

      tx_word(2'b00, 3'd0, 16'hBEEF, "R2");
      tx_word(2'b00, 3'd1, 16'h1234, "R2");
      tx_word(2'b00, 3'd5, 16'h8001, "R2");
      tx_word(2'b01, 3'd0, 16'hAB01, "R3");
      chk("R3", "lsb-first byte", 32'(tx_shift_word), 32'h0080);
      tx_word(2'b10, 3'd0, 16'h0000, "R4");
      chk("R4", "mu zero code", 32'(tx_shift_word), 32'h00FF);
      tx_word(2'b11, 3'd0, 16'h0000, "R5");
      chk("R5", "A zero code", 32'(tx_shift_word), 32'h00D5);
      tx_word(2'b10, 3'd2, 16'h7FFF, "R6");
      chk("R10", "mu positive saturation", 32'(tx_shift_word), 32'h0080);
      tx_word(2'b10, 3'd0, 16'h8000, "R10");
      chk("R10", "mu negative saturation", 32'(tx_shift_word), 32'h0000);
      tx_word(2'b11, 3'd4, 16'h7FFF, "R6");
      chk("R10", "A positive saturation", 32'(tx_shift_word), 32'h00AA);
      tx_word(2'b11, 3'd0, 16'h8000, "R10");
      chk("R10", "A negative saturation", 32'(tx_shift_word), 32'h002A);
      tx_word(2'b10, 3'd0, 16'd8158, "R10");
      tx_word(2'b11, 3'd0, 16'hF000, "R10");

      // R8: valid drops on the cycle after the strobe
      @(negedge clk);
      chk("R8", "tx_valid one cycle", 32'(tx_valid), 32'd0);

      // R9: mode, data and length changes without a strobe are ignored
      tx_word(2'b10, 3'd0, 16'd100, "R4");
      held = tx_shift_word; held_bits = tx_bits;
      tx_mode = 2'b00; tx_wdlen = 3'd2; tx_data = 16'h5A5A;
      repeat (3) @(negedge clk);
      chk("R9", "tx word held", 32'(tx_shift_word), 32'(held));
      chk("R9", "tx bits held", 32'(tx_bits), 32'(held_bits));
      chk("R9", "tx_valid low", 32'(tx_valid), 32'd0);

      rx_word_t(2'b00, 16'hC3A5, "R7");
      rx_word_t(2'b01, 16'h1234, "R7");
      chk("R7", "rx lsb-first", 32'(rx_word), 32'h002C);
      rx_word_t(2'b10, 16'h00FF, "R7");
      chk("R7", "mu decode zero", 32'(rx_word), 32'h0000);
      rx_word_t(2'b10, 16'h0080, "R7");
      chk("R7", "mu decode peak", 32'(rx_word), 32'h1F5F);
      rx_word_t(2'b10, 16'h0000, "R7");
      chk("R7", "mu decode negative peak", 32'(rx_word), 32'hE0A1);
      rx_word_t(2'b11, 16'h00D5, "R7");
      chk("R7", "A decode smallest", 32'(rx_word), 32'h0001);
      rx_word_t(2'b11, 16'h00AA, "R7");
      chk("R7", "A decode peak", 32'(rx_word), 32'h0FC0);
      rx_word_t(2'b11, 16'h002A, "R7");
      chk("R7", "A decode negative peak", 32'(rx_word), 32'hF040);
      @(negedge clk);
      chk("R8", "rx_valid one cycle", 32'(rx_valid), 32'd0);
      held = rx_word;
      rx_mode = 2'b00; rx_buf = 16'h7777;
      repeat (2) @(negedge clk);
      chk("R9", "rx word held", 32'(rx_word), 32'(held));

      for (int i = 0; i < 300; i++) begin
         logic [1:0] md = 2'($urandom);
         tx_word(md, 3'($urandom), pick_sample(),
                 (md == 2'b00) ? "R2" : (md == 2'b01) ? "R3" : (md == 2'b10) ? "R4" : "R5");
      end
      for (int i = 0; i < 300; i++) begin
         rx_word_t(2'($urandom), 16'($urandom), "R7");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule